// File: doc/BRIEF.md
# Configurable D/T/JK Register Cell

This block is one logic cell of a programmable array: a single flip-flop that can act as a D, T or JK register, plus the steering logic around it. Four sum-of-products terms, named A to D and produced by an array outside this block, enter the cell. Static configuration bits give each sum its role. A is the data, toggle or J input. B is K or an asynchronous preset. C is the clock or an asynchronous reset. D is the clock, or a signal that leaves the cell for the pin's output enable or for feedback into the array. A sum can also pass straight through to an output as a combinational path.

A set of global lines reaches every cell: a clock with selectable polarity, a preset, a reset, and a register-type control. A cell configured to follow that control loads like a D register while it is low and counts like a T register while it is high. This lets a loadable counter switch between loading and counting without spending product terms on the choice. Two selectable outputs each carry the register state or one of sums A, B or C. A third output carries sum D, or the register state when sum D is used as the clock.

Top module: `lcell_dtjk`

## Requirements
- R1: With `cfg_kind_i` = 00 (data mode), Q takes the value of sum A at each active clock edge.
- R2: With `cfg_kind_i` = 01 (toggle mode), Q inverts at an active edge when sum A is 1 and keeps its value when sum A is 0.
- R3: With `cfg_kind_i` = 10 (JK mode, J = sum A, K = sum B), at an active edge J/K = 1/0 sets Q, 0/1 clears Q, 1/1 inverts Q and 0/0 keeps Q.
- R4: With `cfg_kind_i` = 11 the cell follows `gcount_i`: low gives data-mode behaviour (load A), high gives toggle-mode behaviour (toggle on A).
- R5: With `cfg_clk_src_i` = 00 or 11 the register is clocked by `gclk_i`: on its rising edge when `cfg_gclk_neg_i` = 0, and on its falling edge when `cfg_gclk_neg_i` = 1.
- R6: With `cfg_clk_src_i` = 01 the register is clocked by the rising edge of sum C, and with 10 by the rising edge of sum D. Edges of `gclk_i` then have no effect.
- R7: `aux_o` equals sum D, except when `cfg_clk_src_i` = 10, when it carries Q.
- R8: Reset (`grst_i`, or sum C when enabled as reset) clears Q at once. Set (`gset_i`, or sum B when enabled as preset) makes Q 1 at once. When both are active, reset wins. When neither is active, Q holds between clock edges.
- R9: With `cfg_c_reset_i` = 1, sum C acts as an asynchronous reset, except when `cfg_clk_src_i` = 01, where it is used only as the clock.
- R10: With `cfg_b_preset_i` = 1, sum B acts as an asynchronous preset, except in JK mode (`cfg_kind_i` = 10), where it is used only as K.
- R11: `out0_o` and `out1_o` each select independently with their 2-bit selects: 00 gives Q, 01 sum A, 10 sum B, 11 sum C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk_i | input | 1 | Global clock |
| grst_i | input | 1 | Global asynchronous reset, active high |
| gset_i | input | 1 | Global asynchronous preset, active high |
| gcount_i | input | 1 | Global register-type control: 0 load, 1 count |
| sum_a_i | input | 1 | Sum A: D, T or J input |
| sum_b_i | input | 1 | Sum B: K input or preset |
| sum_c_i | input | 1 | Sum C: clock or reset |
| sum_d_i | input | 1 | Sum D: clock, enable or feedback |
| cfg_kind_i | input | 2 | Register kind: 00 D, 01 T, 10 JK, 11 follow gcount_i |
| cfg_clk_src_i | input | 2 | Clock source: 00/11 global, 01 sum C, 10 sum D |
| cfg_gclk_neg_i | input | 1 | Global clock active on falling edge |
| cfg_b_preset_i | input | 1 | Use sum B as preset |
| cfg_c_reset_i | input | 1 | Use sum C as reset |
| cfg_out0_sel_i | input | 2 | Select for out0_o |
| cfg_out1_sel_i | input | 2 | Select for out1_o |
| out0_o | output | 1 | First selectable output |
| out1_o | output | 1 | Second selectable output |
| aux_o | output | 1 | Sum D, or Q when sum D clocks the register |

## Verification
The hardest situations to reach are the ones where a sum has two possible roles and one role must silence the other. Sum C, enabled as reset, must not clear a register that it also clocks. Sum B, enabled as preset, must not set a JK register. The stimulus enters these states by holding the competing role's input high in a cycle where that role would visibly change Q: it loads a 1 with sum C held high, or holds K high with Q at 0. Switching clock sources and polarity could itself make a false edge, so the bench changes these settings only at a phase of the global clock where the old and new clock levels agree.

// File: rtl/lcell_pkg.sv
`timescale 1ns/100ps
package lcell_pkg;

    localparam int SEL_W   = 2;
    localparam int N_SUMS  = 4;
    localparam int N_MUXO  = 2;

    typedef enum logic [SEL_W-1:0] {
        KIND_D   = 2'b00,
        KIND_T   = 2'b01,
        KIND_JK  = 2'b10,
        KIND_GLB = 2'b11
    } kind_e;

    typedef enum logic [SEL_W-1:0] {
        CS_GLB     = 2'b00,
        CS_SUMC    = 2'b01,
        CS_SUMD    = 2'b10,
        CS_GLB_ALT = 2'b11
    } clk_src_e;

    typedef enum logic [SEL_W-1:0] {
        OS_Q = 2'b00,
        OS_A = 2'b01,
        OS_B = 2'b10,
        OS_C = 2'b11
    } out_sel_e;

    typedef struct packed {
        logic q;
    } cell_st_t;

    typedef struct packed {
        logic  reg_clk;
        logic  rst;
        logic  set;
        kind_e kind;
        logic  aux;
    } route_t;

endpackage

// File: rtl/lcell_route.sv
`timescale 1ns/100ps
module lcell_route
    import lcell_pkg::*;
(
    input  logic             gclk_i,
    input  logic             grst_i,
    input  logic             gset_i,
    input  logic             gcount_i,
    input  logic             sum_b_i,
    input  logic             sum_c_i,
    input  logic             sum_d_i,
    input  logic             q_i,
    input  logic [SEL_W-1:0] cfg_kind_i,
    input  logic [SEL_W-1:0] cfg_clk_src_i,
    input  logic             cfg_gclk_neg_i,
    input  logic             cfg_b_preset_i,
    input  logic             cfg_c_reset_i,
    output route_t           route_o
);

    kind_e    kind_cfg;
    clk_src_e src_cfg;
    logic     gclk_pol;
    logic     c_is_clk;
    logic     d_is_clk;

    assign kind_cfg = kind_e'(cfg_kind_i);
    assign src_cfg  = clk_src_e'(cfg_clk_src_i);
    assign gclk_pol = gclk_i ^ cfg_gclk_neg_i;
    assign c_is_clk = (src_cfg == CS_SUMC);
    assign d_is_clk = (src_cfg == CS_SUMD);

    always_comb begin
        route_o = '0;

        // clock source
        unique case (src_cfg)
            CS_SUMC:    route_o.reg_clk = sum_c_i;
            CS_SUMD:    route_o.reg_clk = sum_d_i;
            CS_GLB,
            CS_GLB_ALT: route_o.reg_clk = gclk_pol;
        endcase

        // effective register kind; the global control resolves the follow mode
        if (kind_cfg == KIND_GLB) begin
            route_o.kind = gcount_i ? KIND_T : KIND_D;
        end else begin
            route_o.kind = kind_cfg;
        end

        // asynchronous controls: sum C cannot reset when it is the clock,
        // sum B cannot preset when it is the K input
        route_o.rst = grst_i | (cfg_c_reset_i & sum_c_i & ~c_is_clk);
        route_o.set = gset_i | (cfg_b_preset_i & sum_b_i & (kind_cfg != KIND_JK));

        // third output: sum D leaves the cell unless it is consumed as clock
        route_o.aux = d_is_clk ? q_i : sum_d_i;
    end

endmodule

// File: rtl/lcell_core.sv
`timescale 1ns/100ps
module lcell_core
    import lcell_pkg::*;
(
    input  logic  reg_clk_i,
    input  logic  rst_i,
    input  logic  set_i,
    input  kind_e kind_i,
    input  logic  in_j_i,
    input  logic  in_k_i,
    output logic  q_o
);

    cell_st_t st_d;
    cell_st_t st_q;

    always_comb begin
        st_d = st_q;
        unique case (kind_i)
            KIND_D: begin
                st_d.q = in_j_i;
            end
            KIND_T: begin
                st_d.q = st_q.q ^ in_j_i;
            end
            KIND_JK: begin
                unique case ({in_j_i, in_k_i})
                    2'b10:   st_d.q = 1'b1;
                    2'b01:   st_d.q = 1'b0;
                    2'b11:   st_d.q = ~st_q.q;
                    default: st_d.q = st_q.q;
                endcase
            end
            KIND_GLB: begin
                st_d.q = st_q.q;
            end
        endcase
    end

    // reset has priority over set
    always_ff @(posedge reg_clk_i or posedge rst_i or posedge set_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else if (set_i) begin
            st_q <= '{q: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;

endmodule

// File: rtl/lcell_outmux.sv
`timescale 1ns/100ps
module lcell_outmux
    import lcell_pkg::*;
#(
    parameter int N_OUT = N_MUXO
) (
    input  logic [N_OUT-1:0][SEL_W-1:0] sel_i,
    input  logic                        q_i,
    input  logic                        sum_a_i,
    input  logic                        sum_b_i,
    input  logic                        sum_c_i,
    output logic [N_OUT-1:0]            y_o
);

    localparam int N_SRC = 1 << SEL_W;

    logic [N_SRC-1:0] src_vec;

    assign src_vec[OS_Q] = q_i;
    assign src_vec[OS_A] = sum_a_i;
    assign src_vec[OS_B] = sum_b_i;
    assign src_vec[OS_C] = sum_c_i;

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        assign y_o[g] = src_vec[sel_i[g]];
    end

endmodule

// File: rtl/lcell_dtjk.sv
`timescale 1ns/100ps
module lcell_dtjk
    import lcell_pkg::*;
(
    input  logic       gclk_i,
    input  logic       grst_i,
    input  logic       gset_i,
    input  logic       gcount_i,
    input  logic       sum_a_i,
    input  logic       sum_b_i,
    input  logic       sum_c_i,
    input  logic       sum_d_i,
    input  logic [1:0] cfg_kind_i,
    input  logic [1:0] cfg_clk_src_i,
    input  logic       cfg_gclk_neg_i,
    input  logic       cfg_b_preset_i,
    input  logic       cfg_c_reset_i,
    input  logic [1:0] cfg_out0_sel_i,
    input  logic [1:0] cfg_out1_sel_i,
    output logic       out0_o,
    output logic       out1_o,
    output logic       aux_o
);

    route_t                        route;
    logic                          q_w;
    logic                          reg_clk;
    logic                          rst_eff;
    logic                          set_eff;
    logic [N_MUXO-1:0][SEL_W-1:0]  out_sel;
    logic [N_MUXO-1:0]             out_y;

    lcell_route u_route (
        .gclk_i         (gclk_i),
        .grst_i         (grst_i),
        .gset_i         (gset_i),
        .gcount_i       (gcount_i),
        .sum_b_i        (sum_b_i),
        .sum_c_i        (sum_c_i),
        .sum_d_i        (sum_d_i),
        .q_i            (q_w),
        .cfg_kind_i     (cfg_kind_i),
        .cfg_clk_src_i  (cfg_clk_src_i),
        .cfg_gclk_neg_i (cfg_gclk_neg_i),
        .cfg_b_preset_i (cfg_b_preset_i),
        .cfg_c_reset_i  (cfg_c_reset_i),
        .route_o        (route)
    );

    assign reg_clk = route.reg_clk;
    assign rst_eff = route.rst;
    assign set_eff = route.set;

    lcell_core u_core (
        .reg_clk_i (reg_clk),
        .rst_i     (rst_eff),
        .set_i     (set_eff),
        .kind_i    (route.kind),
        .in_j_i    (sum_a_i),
        .in_k_i    (sum_b_i),
        .q_o       (q_w)
    );

    assign out_sel[0] = cfg_out0_sel_i;
    assign out_sel[1] = cfg_out1_sel_i;

    lcell_outmux #(.N_OUT(N_MUXO)) u_outmux (
        .sel_i   (out_sel),
        .q_i     (q_w),
        .sum_a_i (sum_a_i),
        .sum_b_i (sum_b_i),
        .sum_c_i (sum_c_i),
        .y_o     (out_y)
    );

    assign out0_o = out_y[0];
    assign out1_o = out_y[1];
    assign aux_o  = route.aux;

endmodule

// File: rtl/lcell_dtjk_chk.sv
`timescale 1ns/100ps
module lcell_dtjk_chk (
    input logic       gclk_i,
    input logic       grst_i,
    input logic       gset_i,
    input logic       gcount_i,
    input logic       sum_a_i,
    input logic       sum_b_i,
    input logic       sum_d_i,
    input logic [1:0] cfg_kind_i,
    input logic [1:0] cfg_clk_src_i,
    input logic       cfg_gclk_neg_i,
    input logic       cfg_b_preset_i,
    input logic       cfg_c_reset_i,
    input logic [1:0] cfg_out0_sel_i,
    input logic [1:0] cfg_out1_sel_i,
    input logic       out0_o,
    input logic       out1_o,
    input logic       aux_o,
    input logic       q_w,
    input logic       rst_eff,
    input logic       set_eff
);

    logic       arm_q;
    logic       ck_rst;
    logic       pos_gclk;
    logic       quiet;
    logic [6:0] cfg_all;

    always_ff @(posedge gclk_i or posedge grst_i) begin
        if (grst_i) begin
            arm_q <= 1'b0;
        end else begin
            arm_q <= 1'b1;
        end
    end

    assign ck_rst   = ~arm_q;
    assign pos_gclk = (cfg_clk_src_i[0] == cfg_clk_src_i[1]) && !cfg_gclk_neg_i;
    assign quiet    = !rst_eff && !set_eff;
    assign cfg_all  = {cfg_kind_i, cfg_clk_src_i, cfg_gclk_neg_i, cfg_b_preset_i, cfg_c_reset_i};

    AST_D_LOAD: assert property (@(posedge gclk_i) disable iff (ck_rst)
        (pos_gclk && $past(pos_gclk) && $stable(cfg_all) && quiet && $past(quiet)
         && cfg_kind_i == 2'b00) |-> (q_w == $past(sum_a_i)));                         // R1

    AST_T_TOGGLE: assert property (@(posedge gclk_i) disable iff (ck_rst)
        (pos_gclk && $past(pos_gclk) && $stable(cfg_all) && quiet && $past(quiet)
         && cfg_kind_i == 2'b01) |-> (q_w == ($past(q_w) ^ $past(sum_a_i))));          // R2

    AST_JK_SET: assert property (@(posedge gclk_i) disable iff (ck_rst)
        (pos_gclk && $past(pos_gclk) && $stable(cfg_all) && quiet && $past(quiet)
         && cfg_kind_i == 2'b10 && $past(sum_a_i) && !$past(sum_b_i)) |-> q_w);       // R3

    AST_JK_CLR: assert property (@(posedge gclk_i) disable iff (ck_rst)
        (pos_gclk && $past(pos_gclk) && $stable(cfg_all) && quiet && $past(quiet)
         && cfg_kind_i == 2'b10 && !$past(sum_a_i) && $past(sum_b_i)) |-> !q_w);      // R3

    AST_GLB_LOAD: assert property (@(posedge gclk_i) disable iff (ck_rst)
        (pos_gclk && $past(pos_gclk) && $stable(cfg_all) && quiet && $past(quiet)
         && cfg_kind_i == 2'b11 && !$past(gcount_i)) |-> (q_w == $past(sum_a_i)));    // R4

    AST_RST_WINS: assert property (@(posedge gclk_i) disable iff (ck_rst)
        rst_eff |-> !q_w);                                                             // R8

    AST_SET_ONLY: assert property (@(posedge gclk_i) disable iff (ck_rst)
        (set_eff && !rst_eff) |-> q_w);                                                // R8

    AST_JK_NO_PRESET: assert property (@(posedge gclk_i) disable iff (ck_rst)
        (cfg_kind_i == 2'b10 && !gset_i) |-> !set_eff);                                // R10

    AST_AUX_ROUTE: assert property (@(posedge gclk_i) disable iff (ck_rst)
        aux_o == ((cfg_clk_src_i == 2'b10) ? q_w : sum_d_i));                          // R7

    AST_OUT0_A: assert property (@(posedge gclk_i) disable iff (ck_rst)
        (cfg_out0_sel_i == 2'b01) |-> (out0_o == sum_a_i));                            // R11

    AST_OUT1_Q: assert property (@(posedge gclk_i) disable iff (ck_rst)
        (cfg_out1_sel_i == 2'b00) |-> (out1_o == q_w));                                // R11

endmodule

bind lcell_dtjk lcell_dtjk_chk u_chk (
    .gclk_i         (gclk_i),
    .grst_i         (grst_i),
    .gset_i         (gset_i),
    .gcount_i       (gcount_i),
    .sum_a_i        (sum_a_i),
    .sum_b_i        (sum_b_i),
    .sum_d_i        (sum_d_i),
    .cfg_kind_i     (cfg_kind_i),
    .cfg_clk_src_i  (cfg_clk_src_i),
    .cfg_gclk_neg_i (cfg_gclk_neg_i),
    .cfg_b_preset_i (cfg_b_preset_i),
    .cfg_c_reset_i  (cfg_c_reset_i),
    .cfg_out0_sel_i (cfg_out0_sel_i),
    .cfg_out1_sel_i (cfg_out1_sel_i),
    .out0_o         (out0_o),
    .out1_o         (out1_o),
    .aux_o          (aux_o),
    .q_w            (q_w),
    .rst_eff        (rst_eff),
    .set_eff        (set_eff)
);

// File: tb/lcell_dtjk_bench.sv
`timescale 1ns/100ps
module lcell_dtjk_bench;

    logic       gclk = 1'b0;
    logic       grst, gset, gcount;
    logic       sa, sb, sc, sd;
    logic [1:0] kind, src, sel0, sel1;
    logic       gneg, bpre, crst;
    logic       out0, out1, aux;

    int   n_vec = 0;
    int   n_bad = 0;
    logic q_m   = 1'b0;
    logic done  = 1'b0;

    always #2 gclk = ~gclk;   // 250 MHz

    lcell_dtjk u_lcell_dtjk (
        .gclk_i         (gclk),
        .grst_i         (grst),
        .gset_i         (gset),
        .gcount_i       (gcount),
        .sum_a_i        (sa),
        .sum_b_i        (sb),
        .sum_c_i        (sc),
        .sum_d_i        (sd),
        .cfg_kind_i     (kind),
        .cfg_clk_src_i  (src),
        .cfg_gclk_neg_i (gneg),
        .cfg_b_preset_i (bpre),
        .cfg_c_reset_i  (crst),
        .cfg_out0_sel_i (sel0),
        .cfg_out1_sel_i (sel1),
        .out0_o         (out0),
        .out1_o         (out1),
        .aux_o          (aux)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_next(input logic [1:0] k, input logic g,
                                        input logic q, input logic a, input logic b);
        logic [1:0] e;
        e = (k == 2'b11) ? (g ? 2'b01 : 2'b00) : k;
        case (e)
            2'b00:   return a;
            2'b01:   return q ^ a;
            default: return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
        endcase
    endfunction

    function automatic logic pick(input logic [1:0] s, input logic q,
                                  input logic a, input logic b, input logic c);
        case (s)
            2'b00:   return q;
            2'b01:   return a;
            2'b10:   return b;
            default: return c;
        endcase
    endfunction

    function automatic string kind_req(input logic [1:0] k);
        case (k)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        grst = 1'b1; gset = 1'b0; gcount = 1'b0;
        sa = 1'b0; sb = 1'b0; sc = 1'b0; sd = 1'b0;
        kind = 2'b00; src = 2'b00; sel0 = 2'b00; sel1 = 2'b00;
        gneg = 1'b0; bpre = 1'b0; crst = 1'b0;
        repeat (3) @(posedge gclk);
        #0.5;
        chk("R8 reset state", out0, 1'b0);
        @(negedge gclk);
        #0.5 grst = 1'b0;
        q_m = 1'b0;

        // register kinds, global type control, global positive clock
        for (int k = 0; k < 4; k++) begin
            for (int g = 0; g < 2; g++) begin
                for (int pass = 0; pass < 3; pass++) begin
                    for (int ab = 0; ab < 4; ab++) begin
                        @(negedge gclk);
                        #0.5;
                        kind = 2'(k); gcount = 1'(g);
                        sa = ab[1]; sb = ab[0];
                        @(posedge gclk);
                        #0.5;
                        q_m = model_next(2'(k), 1'(g), q_m, ab[1], ab[0]);
                        chk(kind_req(2'(k)), out0, q_m);
                    end
                end
            end
        end

        // R5: falling-edge global clock; switch while gclk is high
        kind = 2'b00; gcount = 1'b0; sb = 1'b0;
        @(posedge gclk);
        #0.5 gneg = 1'b1; sa = q_m;
        for (int i = 0; i < 8; i++) begin
            automatic logic v = i[0] ^ i[1];
            @(posedge gclk);
            #0.5;
            chk("R5 rising edge ignored", out0, q_m);
            sa = v;
            @(negedge gclk);
            #0.5;
            q_m = v;
            chk("R5 falling edge loads", out0, q_m);
        end
        #0.5 gneg = 1'b0;   // gclk low here: no false edge

        // R6/R9: sum C as clock, with sum C also enabled as reset
        @(negedge gclk);
        #0.5 src = 2'b01; crst = 1'b1; sc = 1'b0;
        for (int i = 0; i < 8; i++) begin
            automatic logic v = i[0];
            @(negedge gclk);
            #0.5 sa = v;
            @(posedge gclk);
            #0.5;
            chk("R6 global edge ignored", out0, q_m);
            sc = 1'b1;
            #0.5;
            q_m = v;
            chk(v ? "R9 clock sum does not reset" : "R6 sum C edge loads", out0, q_m);
            sc = 1'b0;
        end

        // R6/R7: sum D as clock, aux carries Q
        @(negedge gclk);
        #0.5 src = 2'b10; crst = 1'b0; sd = 1'b0;
        for (int i = 0; i < 8; i++) begin
            automatic logic v = i[0] ^ i[2];
            @(negedge gclk);
            #0.5 sa = v;
            @(posedge gclk);
            #0.5;
            chk("R6 global edge ignored", out0, q_m);
            sd = 1'b1;
            #0.5;
            q_m = v;
            chk("R6 sum D edge loads", out0, q_m);
            chk("R7 aux carries Q", aux, q_m);
            sd = 1'b0;
        end
        @(negedge gclk);
        #0.5 src = 2'b00;

        // R8/R9/R10: asynchronous reset and set sources and their priority
        kind = 2'b00; bpre = 1'b1; crst = 1'b1;
        for (int pre = 0; pre < 2; pre++) begin
            for (int m = 0; m < 16; m++) begin
                automatic logic rs  = m[3] | m[0];
                automatic logic st  = m[2] | m[1];
                automatic logic exp = rs ? 1'b0 : (st ? 1'b1 : 1'(pre));
                @(negedge gclk);
                #0.5;
                grst = 1'b0; gset = 1'b0; sb = 1'b0; sc = 1'b0; sa = 1'(pre);
                @(posedge gclk);
                #0.5 q_m = 1'(pre);
                @(negedge gclk);
                #0.5;
                grst = m[3]; gset = m[2]; sb = m[1]; sc = m[0];
                #0.5;
                chk((rs && st) ? "R8 reset beats set" :
                    (m[0] ? "R9 sum C resets" : (m[1] ? "R10 sum B presets" : "R8 async")),
                    out0, exp);
                @(posedge gclk);
                #0.5;
                chk("R8 async held over edge", out0, exp);
                q_m = exp;
            end
        end
        @(negedge gclk);
        #0.5 grst = 1'b0; gset = 1'b0; sc = 1'b0; crst = 1'b0;
        kind = 2'b10; sa = 1'b0; sb = 1'b1;
        @(posedge gclk);
        #0.5 q_m = 1'b0;
        chk("R10 JK clears with K", out0, q_m);
        @(negedge gclk);
        #0.5;
        chk("R10 sum B no preset in JK", out0, 1'b0);
        #0.5 kind = 2'b00; sb = 1'b0; bpre = 1'b0; sa = 1'b0;
        @(posedge gclk);
        #0.5 q_m = 1'b0;

        // R11/R7: output selection sweep
        for (int s0 = 0; s0 < 4; s0++) begin
            for (int s1 = 0; s1 < 4; s1++) begin
                for (int v = 0; v < 8; v++) begin
                    @(negedge gclk);
                    #0.5;
                    sel0 = 2'(s0); sel1 = 2'(s1);
                    sa = v[0]; sb = v[1]; sc = v[2]; sd = v[0] ^ v[1];
                    #0.5;
                    chk("R11 out0", out0, pick(2'(s0), q_m, v[0], v[1], v[2]));
                    chk("R11 out1", out1, pick(2'(s1), q_m, v[0], v[1], v[2]));
                    chk("R7 aux carries sum D", aux, v[0] ^ v[1]);
                    @(posedge gclk);
                    #0.5 q_m = v[0];
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge gclk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule